// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a serial-peripheral slave that holds the small control bank of a line equalizer. A host selects it by pulling `ss_n` low and clocks frames in on `sck`/`mosi`. A write frame carries a direction bit, an address and a data byte. A read frame carries only the direction bit and the address. The addressed byte then comes back on `miso` within the same select window, with no turnaround gap.

The bank has four byte-wide locations. Three of them are writable control registers, and their fields leave the block as parallel outputs. The fourth location reports a cable-length code read-only. Location 0 also carries a live carrier flag read-only. Reserved bits always read back as zero.

All serial inputs are oversampled by the system clock `clk` through synchronizer chains. The whole block therefore sits in one clock domain. `sck` must stay at least several `clk` periods in each phase.

Top module: `cfg_spi_slave`

## Requirements
- R1: After reset the control outputs are: mute 0, sleep mode 2'b01, extended reach 0, swing 3'b011, offset 3'b001, coarse 0, fine 4'b0000. `miso_oe` is 0 and `miso` is high impedance.
- R2: A write frame is 16 `sck` rising edges, sampled MSB first: bit 15 = 0 (write), bits 14:8 = address, bits 7:0 = data. Once `ss_n` rises, the addressed register holds the data and its fields appear on the outputs. Location 1 maps swing to data bits 7:5 and offset to 4:2. Location 2 maps coarse to bit 7 and fine to 6:3.
- R3: In a read frame (bit 15 = 1, then a 7-bit address), `miso_oe` stays low through the 8th rising edge. From the 8th falling edge on, `miso` presents the addressed byte MSB first, one bit per falling edge, ready for rising edges 9 to 16.
- R4: Location 0 reads as {carrier_ok, mute, 0, sleep[1:0], ext_reach, 2'b00}. Writes to location 0 set mute from bit 6, sleep from bits 4:3 and extended reach from bit 2. Bit 7 stays the live `carrier_ok` input and cannot be written.
- R5: Location 3 reads as {cable_len[4:0], 3'b000}, and writes to it change nothing.
- R6: Reserved bits read as 0 regardless of the written data: bits 5 and 1:0 of location 0, bits 1:0 of location 1, and bits 2:0 of location 2.
- R7: A write frame ended by `ss_n` rising before the 16th rising edge changes no register.
- R8: Reads of addresses 04h to 7Fh return 00h. Writes to them change no output.
- R9: `miso_oe` is 0 throughout any write frame and returns to 0 after `ss_n` rises. `miso` is high impedance whenever `miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ss_n | input | 1 | Active-low slave select |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, high impedance when not driven |
| miso_oe | output | 1 | High while `miso` is driven |
| carrier_ok | input | 1 | Carrier-present status, reported in location 0 bit 7 |
| cable_len | input | 5 | Cable-length code, reported in location 3 bits 7:3 |
| eq_mute | output | 1 | Mute control |
| eq_sleep | output | 2 | Sleep-mode control |
| eq_ext_reach | output | 1 | Extended-reach enable |
| drv_swing | output | 3 | Output swing code |
| drv_offset | output | 3 | Output offset code |
| lnch_coarse | output | 1 | Coarse launch-amplitude control |
| lnch_fine | output | 4 | Fine launch-amplitude control |

## Verification
Read frames are sent at reset and after writes of bytes with all bits set, mixed patterns such as 8Fh and 37h, and sparse values. These show that field masking works and that the direction bit selects the byte. The asymmetric bit patterns expose any reversal of bit order. The carrier flag and cable code are toggled between reads, which separates live status from stored bits. A write cut off after 12 edges, plus writes and reads aimed at location 3 and at addresses above it, confirm that those frames leave every output unchanged.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
  localparam int NUM_LOC = 4;
  localparam int NUM_RW  = 3;

  // Reset value of each writable location
  function automatic logic [7:0] loc_default(input int idx);
    case (idx)
      0:       return 8'h08;
      1:       return 8'h64;
      default: return 8'h00;
    endcase
  endfunction

  // Bits a host write may change
  function automatic logic [7:0] loc_wmask(input int idx);
    case (idx)
      0:       return 8'h5C;
      1:       return 8'hFC;
      2:       return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction

  // Byte seen by a host read of a writable location
  function automatic logic [7:0] loc_view(input int idx, input logic [7:0] stored,
                                          input logic carrier);
    return (idx == 0) ? (stored | {carrier, 7'b0}) : stored;
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int  STAGES = 2,
  parameter logic INIT  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= INIT;
        else        chain[s] <= (s == 0) ? d : chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate
  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_frame.sv
module cfg_frame #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int HDR_BITS = ADDR_W + 1,
  localparam int FRM_BITS = HDR_BITS + DATA_W,
  localparam int CNT_W    = $clog2(FRM_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,      // synchronized, active high
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sdi,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-2:0] shreg;
  logic              is_read;
  logic              fetch_stb;
  logic [DATA_W-1:0] tx_q;

  wire hdr_done = sel && sck_rise && (bit_cnt == CNT_W'(HDR_BITS - 1));
  wire last_bit = sel && sck_rise && (bit_cnt == CNT_W'(FRM_BITS - 1));
  wire in_data  = (bit_cnt >= CNT_W'(HDR_BITS)) && (bit_cnt < CNT_W'(FRM_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      is_read   <= 1'b0;
      addr_q    <= '0;
      fetch_stb <= 1'b0;
      tx_q      <= '0;
      sdo       <= 1'b0;
      sdo_oe    <= 1'b0;
      wr_stb    <= 1'b0;
      wr_data   <= '0;
    end else begin
      fetch_stb <= 1'b0;
      wr_stb    <= 1'b0;
      if (!sel) begin
        bit_cnt <= '0;
        is_read <= 1'b0;
        sdo_oe  <= 1'b0;
      end else begin
        if (sck_rise && bit_cnt < CNT_W'(FRM_BITS)) begin
          bit_cnt <= bit_cnt + 1'b1;
          shreg   <= {shreg[DATA_W-3:0], sdi};
        end
        if (hdr_done) begin
          is_read   <= shreg[ADDR_W-1];
          addr_q    <= {shreg[ADDR_W-2:0], sdi};
          fetch_stb <= shreg[ADDR_W-1];
        end
        if (last_bit && !is_read) begin
          wr_stb  <= 1'b1;
          wr_data <= {shreg, sdi};
        end
        if (fetch_stb) tx_q <= rd_data;
        if (sck_fall && is_read && in_data) begin
          sdo    <= tx_q[DATA_W-1];
          tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
          sdo_oe <= 1'b1;
        end
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRM_BITS)); // R7
  AST_WR_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (bit_cnt == CNT_W'(FRM_BITS)) && sel); // R7
  AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> is_read); // R9
  AST_OE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(bit_cnt) == CNT_W'(HDR_BITS)); // R3
endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_spi_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int LEN_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_stb,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wr_data,
  input  logic                    carrier_ok,
  input  logic [LEN_W-1:0]        cable_len,
  output logic [7:0]              rd_data,
  output logic [NUM_RW-1:0][7:0]  regs
);
  generate
    for (genvar g = 0; g < NUM_RW; g++) begin : g_loc
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs[g] <= loc_default(g);
        else if (wr_stb && addr == ADDR_W'(g))
          regs[g] <= wr_data & loc_wmask(g);
      end
    end
  endgenerate

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_RW; i++)
      if (addr == ADDR_W'(i)) rd_data = loc_view(i, regs[i], carrier_ok);
    if (addr == ADDR_W'(NUM_LOC - 1))
      rd_data = {cable_len, {(8 - LEN_W){1'b0}}};
  end

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(regs)); // R8
  AST_FAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr >= ADDR_W'(NUM_RW)) |=> $stable(regs)); // R5
endmodule

// File: rtl/cfg_spi_slave.sv
module cfg_spi_slave
  import cfg_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7,
  parameter int LEN_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ss_n,
  input  logic             sck,
  input  logic             mosi,
  output logic             miso,
  output logic             miso_oe,
  input  logic             carrier_ok,
  input  logic [LEN_W-1:0] cable_len,
  output logic             eq_mute,
  output logic [1:0]       eq_sleep,
  output logic             eq_ext_reach,
  output logic [2:0]       drv_swing,
  output logic [2:0]       drv_offset,
  output logic             lnch_coarse,
  output logic [3:0]       lnch_fine
);
  logic ss_s, sck_s, mosi_s, sck_d;
  logic [ADDR_W-1:0] addr;
  logic wr_stb, sdo;
  logic [7:0] wr_data, rd_data;
  logic [NUM_RW-1:0][7:0] regs;

  cfg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_ss   (.clk(clk), .rst_n(rst_n), .d(ss_n), .q(ss_s));
  cfg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sck  (.clk(clk), .rst_n(rst_n), .d(sck),  .q(sck_s));
  cfg_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_mosi (.clk(clk), .rst_n(rst_n), .d(mosi), .q(mosi_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  wire sck_rise = sck_s & ~sck_d;
  wire sck_fall = ~sck_s & sck_d;

  cfg_frame #(.ADDR_W(ADDR_W), .DATA_W(8)) u_frame (
    .clk(clk), .rst_n(rst_n), .sel(~ss_s), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sdi(mosi_s), .rd_data(rd_data), .addr_q(addr), .wr_stb(wr_stb),
    .wr_data(wr_data), .sdo(sdo), .sdo_oe(miso_oe));

  cfg_regbank #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(addr), .wr_data(wr_data),
    .carrier_ok(carrier_ok), .cable_len(cable_len), .rd_data(rd_data), .regs(regs));

  assign miso = miso_oe ? sdo : 1'bz;

  assign eq_mute      = regs[0][6];
  assign eq_sleep     = regs[0][4:3];
  assign eq_ext_reach = regs[0][2];
  assign drv_swing    = regs[1][7:5];
  assign drv_offset   = regs[1][4:2];
  assign lnch_coarse  = regs[2][7];
  assign lnch_fine    = regs[2][6:3];

  AST_OE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ss_s |=> !miso_oe); // R9
  AST_WR_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !ss_s); // R2
endmodule

// File: tb/tb_cfg_spi_slave.sv
module tb_cfg_spi_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ss_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic carrier_ok = 1'b0;
  logic [4:0] cable_len = 5'd0;
  wire miso, miso_oe, eq_mute, eq_ext_reach, lnch_coarse;
  wire [1:0] eq_sleep;
  wire [2:0] drv_swing, drv_offset;
  wire [3:0] lnch_fine;
  int errors = 0, checks = 0;
  localparam int HALF = 8;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t expq[$];

  always #2.5 clk = ~clk;

  cfg_spi_slave dut (.clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .carrier_ok(carrier_ok), .cable_len(cable_len),
    .eq_mute(eq_mute), .eq_sleep(eq_sleep), .eq_ext_reach(eq_ext_reach),
    .drv_swing(drv_swing), .drv_offset(drv_offset), .lnch_coarse(lnch_coarse),
    .lnch_fine(lnch_fine));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  // drive nbits MSB first; optionally check oe state mid-frame
  task automatic shift_frame(input logic [15:0] word, input int nbits, input bit is_rd);
    ss_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 8 || !is_rd) ? word[15-i] : 1'b0;
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF - 2);
      if (!is_rd && i == 11) chk("R9 oe low in write", miso_oe, 1'b0);
      if (is_rd && i == 7) chk("R3 oe low before 8th fall", miso_oe, 1'b0);
      wait_clk(2);
      sck = 1'b0;
    end
    wait_clk(HALF);
    ss_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    shift_frame({1'b0, a, d}, 16, 1'b0);
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] e, input string tag);
    exp_t x;
    x.val = e; x.tag = tag;
    expq.push_back(x);
    shift_frame({1'b1, a, 8'h00}, 16, 1'b1);
    chk("R9 oe low after ss", miso_oe, 1'b0);
  endtask

  // monitor: collect bits on host rising edges while driven
  initial begin
    logic [7:0] got;
    int n;
    n = 0; got = '0;
    forever begin
      @(posedge sck or posedge ss_n);
      if (ss_n) n = 0;
      else if (miso_oe) begin
        got = {got[6:0], miso};
        n++;
        if (n == 8) begin
          if (expq.size() == 0) chk("R3 unexpected read data", got, 8'hxx);
          else begin
            exp_t x;
            x = expq.pop_front();
            chk(x.tag, got, x.val);
          end
          n = 0;
        end
      end
    end
  end

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R1 reset state
    chk("R1 mute", eq_mute, 1'b0);
    chk("R1 sleep", eq_sleep, 2'b01);
    chk("R1 ext", eq_ext_reach, 1'b0);
    chk("R1 swing", drv_swing, 3'b011);
    chk("R1 offset", drv_offset, 3'b001);
    chk("R1 coarse", lnch_coarse, 1'b0);
    chk("R1 fine", lnch_fine, 4'b0000);
    chk("R1 oe", miso_oe, 1'b0);
    chk("R9 miso z", miso === 1'bz, 1'b1);
    rd(7'h01, 8'h64, "R1 R3 read loc1 default");
    rd(7'h00, 8'h08, "R1 R4 read loc0 default");
    // R2 write location 1
    wr(7'h01, 8'h8F);
    chk("R2 swing", drv_swing, 3'b100);
    chk("R2 offset", drv_offset, 3'b011);
    rd(7'h01, 8'h8C, "R6 R2 loc1 reserved cleared");
    // R4 location 0 all ones
    wr(7'h00, 8'hFF);
    chk("R4 mute", eq_mute, 1'b1);
    chk("R4 sleep", eq_sleep, 2'b11);
    chk("R4 ext", eq_ext_reach, 1'b1);
    rd(7'h00, 8'h5C, "R4 R6 loc0 no carrier");
    carrier_ok = 1'b1;
    rd(7'h00, 8'hDC, "R4 loc0 carrier live");
    wr(7'h00, 8'h10);
    chk("R4 sleep force", eq_sleep, 2'b10);
    chk("R4 mute cleared", eq_mute, 1'b0);
    // R2 location 2
    wr(7'h02, 8'h37);
    chk("R2 fine", lnch_fine, 4'b0110);
    chk("R2 coarse", lnch_coarse, 1'b0);
    rd(7'h02, 8'h30, "R6 loc2 reserved cleared");
    wr(7'h02, 8'hC0);
    chk("R2 coarse set", lnch_coarse, 1'b1);
    // R5 location 3
    cable_len = 5'b10110;
    rd(7'h03, 8'hB0, "R5 cable code");
    wr(7'h03, 8'hFF);
    cable_len = 5'd25;
    rd(7'h03, 8'hC8, "R5 after write ignored");
    // R7 truncated write
    shift_frame({1'b0, 7'h01, 8'h00}, 12, 1'b0);
    chk("R7 swing kept", drv_swing, 3'b100);
    chk("R7 offset kept", drv_offset, 3'b011);
    rd(7'h01, 8'h8C, "R7 loc1 kept");
    // R8 far addresses
    wr(7'h05, 8'hFF);
    chk("R8 swing kept", drv_swing, 3'b100);
    chk("R8 sleep kept", eq_sleep, 2'b10);
    chk("R8 fine kept", lnch_fine, 4'b1000);
    rd(7'h05, 8'h00, "R8 read 05");
    rd(7'h7F, 8'h00, "R8 read 7F");
    chk("R3 all reads seen", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule